// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters from a host into asynchronous serial frames on one output line. The host writes a character, with an optional ninth bit, into a holding register. Once the serial shifter is free, the character moves into it, and the bits go out at a rate set by an external baud-tick strobe. Because of this double buffering, the host can queue the next character while the current one is still on the line. The queued frame then starts on the clock edge that ends the previous stop bit.

Each frame has a low start bit, the data bits sent least-significant first, and a high stop bit. A mode input selects either eight data bits or nine, with the ninth bit sent last. A break request replaces the next frame with a frame-length stretch of low level. The break repeats for every frame boundary at which the request is still held. Two flags report status: one shows that the holding register can take a new character, and one shows that the line has finished all of its work.

Top module: `ser_tx_dbuf`

## Requirements
- R1: A data frame on `txd` is one low start bit, then data bits least-significant first, then one high stop bit. Each bit lasts exactly 16 `baud_tick` pulses, counted from the frame's first clock edge.
- R2: With `nine_bit_mode` high when a frame is loaded, the frame holds 9 data bits (`wr_bit9` sent after data bit 7), for 11 bit times in total. With the input low, the frame holds 8 data bits, for 10 bit times.
- R3: A write (`wr_en` high) while `hold_empty` is high captures `wr_data` and `wr_bit9`, and `hold_empty` reads low on the following cycle.
- R4: A write while `hold_empty` is low is ignored. The waiting character is the one that is sent later.
- R5: When the shifter is idle and `tx_enable` is high, a waiting character moves into the shifter on the next clock edge, and `hold_empty` rises on that edge.
- R6: When a character is waiting at the end of a frame, its start bit begins on the clock edge that ends the previous stop bit, with no idle time between the frames.
- R7: `tx_done` goes low on the edge where any frame is loaded. It goes high again on the edge where a frame ends and no new frame is loaded.
- R8: `txd` is high whenever no frame is in progress. While `tx_enable` is low, no new frame starts, but a frame already in progress runs to completion, and a waiting character stays in the holding register.
- R9: When `send_break` is high at a frame boundary (shifter idle, or end of a frame) with `tx_enable` high, `txd` stays low for one whole frame time (10 or 11 bit times, chosen by `nine_bit_mode`). This repeats at every boundary while the request is held.
- R10: At a frame boundary, a break request takes priority over a waiting character. That character stays queued and is sent after the break ends.
- R11: After reset, `txd` is high, `hold_empty` is high and `tx_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit time |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character data bits |
| wr_bit9 | input | 1 | Ninth data bit, used in 9-bit mode |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_enable | input | 1 | Allows new frames to start |
| send_break | input | 1 | Requests break frames at frame boundaries |
| hold_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | No frame in progress and none started |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `nine_bit_mode` does not change while a frame is on the line. They also assume that the host writes only after it has seen `hold_empty`, apart from the deliberate ignored-write case. The stimulus changes the mode, the tick spacing and the tick rate only while the line is idle, and drives every input half a cycle away from the active edge. A write to a full register is made on purpose, and the bench leaves it out of the expected stream, so an overwritten character shows up as a frame mismatch.

// File: rtl/stx_pkg.sv
// Shared types for the double-buffered serial transmitter.
// Assumes nothing beyond being compiled first.
package stx_pkg;
    // What the boundary arbiter loads into the shifter.
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_DATA  = 2'd1,
        LD_BREAK = 2'd2
    } load_kind_e;
endpackage

// File: rtl/stx_hold_reg.sv
// Parallel holding register in front of the shifter.
// Captures a host write only when empty; emptied when the shifter takes it.
// Assumes 'take' is raised only while the register is full.
module stx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              take,
    output logic              hold_empty,
    output logic [DATA_W:0]   hold_word
);
    // Fill on a write to an empty register, drain on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_empty <= 1'b1;
            hold_word  <= '0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end else if (wr_en && hold_empty) begin
            hold_word  <= {wr_bit9, wr_data};
            hold_empty <= 1'b0;
        end
    end

    p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_empty && wr_en) |=> !hold_empty);

    p_ignore_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && wr_en && !take) |=> (!hold_empty && $stable(hold_word)));

    p_take_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !hold_empty);
endmodule

// File: rtl/stx_bit_timer.sv
// Bit and frame timer: counts baud ticks within a bit and bits within a frame.
// Restarted on each frame load, with the frame length latched at that moment.
// Assumes frame_bits is at least 1 and 'active' is high only during a frame.
module stx_bit_timer #(
    parameter int TICKS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [IDX_W-1:0] frame_bits,
    input  logic             active,
    input  logic             baud_tick,
    output logic             bit_end,
    output logic             frame_end
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CNT_W-1:0] tick_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] frame_len;

    // A bit ends on the last tick of its slot; a frame ends on its last bit.
    always_comb begin
        bit_end   = active && baud_tick && (tick_cnt == CNT_W'(TICKS - 1));
        frame_end = bit_end && (bit_idx == frame_len - IDX_W'(1));
    end

    // Advance the tick and bit counters; restart wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            bit_idx   <= '0;
            frame_len <= '0;
        end else if (restart) begin
            tick_cnt  <= '0;
            bit_idx   <= '0;
            frame_len <= frame_bits;
        end else if (bit_end) begin
            tick_cnt  <= '0;
            bit_idx   <= bit_idx + IDX_W'(1);
        end else if (active && baud_tick) begin
            tick_cnt  <= tick_cnt + CNT_W'(1);
        end
    end

    p_idx_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx < frame_len));
endmodule

// File: rtl/stx_shifter.sv
// Serial shift register driving the line.
// Loaded only from the arbiter (data or break pattern), shifts right on each
// bit end filling with ones, and returns the line high when a frame ends.
// Assumes 'load' and 'frame_end' come from the same frame timing.
module stx_shifter #(
    parameter int SH_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            load_brk,
    input  logic [SH_W-1:0] load_word,
    input  logic            bit_end,
    input  logic            frame_end,
    output logic            busy,
    output logic            brk_frame,
    output logic            txd
);
    logic [SH_W-1:0] sh;

    // Line level: shifter LSB during a frame, idle high otherwise.
    always_comb txd = busy ? sh[0] : 1'b1;

    // Load, shift, or retire the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            brk_frame <= 1'b0;
            sh        <= '1;
        end else if (load) begin
            busy      <= 1'b1;
            brk_frame <= load_brk;
            sh        <= load_word;
        end else if (frame_end) begin
            busy      <= 1'b0;
            brk_frame <= 1'b0;
            sh        <= '1;
        end else if (bit_end) begin
            sh        <= {1'b1, sh[SH_W-1:1]};
        end
    end

    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && brk_frame) |-> !txd);
endmodule

// File: rtl/ser_tx_dbuf.sv
// Double-buffered asynchronous serial transmitter, top level.
// Arbitrates at each frame boundary between a break, a queued character and
// idle; builds the framed word for 8- or 9-bit mode; tracks completion.
// Assumes nine_bit_mode is steady while a frame is in progress.
module ser_tx_dbuf #(
    parameter int DATA_W = 8,
    parameter int TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              nine_bit_mode,
    input  logic              tx_enable,
    input  logic              send_break,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              txd
);
    import stx_pkg::*;

    localparam int SH_W  = DATA_W + 3;
    localparam int IDX_W = $clog2(SH_W + 1);

    logic [DATA_W:0]  hold_word;
    logic             busy, brk_frame, bit_end, frame_end, boundary;
    logic [SH_W-1:0]  load_word;
    logic [IDX_W-1:0] frame_bits;
    load_kind_e       kind;

    // Frame boundary arbitration: break first, then queued data.
    always_comb begin
        boundary = !busy || frame_end;
        kind     = LD_NONE;
        if (boundary && tx_enable) begin
            if (send_break)       kind = LD_BREAK;
            else if (!hold_empty) kind = LD_DATA;
        end
    end

    // Frame length and framed word for the selected mode.
    always_comb begin
        frame_bits = nine_bit_mode ? IDX_W'(DATA_W + 3) : IDX_W'(DATA_W + 2);
        if (kind == LD_BREAK)
            load_word = '0;
        else if (nine_bit_mode)
            load_word = {1'b1, hold_word[DATA_W], hold_word[DATA_W-1:0], 1'b0};
        else
            load_word = {2'b11, hold_word[DATA_W-1:0], 1'b0};
    end

    // Completion flag: clear on any load, set when a frame ends unreplaced.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_done <= 1'b1;
        else if (kind != LD_NONE)
            tx_done <= 1'b0;
        else if (frame_end)
            tx_done <= 1'b1;
    end

    stx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_bit9    (wr_bit9),
        .take       (kind == LD_DATA),
        .hold_empty (hold_empty),
        .hold_word  (hold_word)
    );

    stx_bit_timer #(.TICKS(TICKS), .IDX_W(IDX_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (kind != LD_NONE),
        .frame_bits (frame_bits),
        .active     (busy),
        .baud_tick  (baud_tick),
        .bit_end    (bit_end),
        .frame_end  (frame_end)
    );

    stx_shifter #(.SH_W(SH_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (kind != LD_NONE),
        .load_brk   (kind == LD_BREAK),
        .load_word  (load_word),
        .bit_end    (bit_end),
        .frame_end  (frame_end),
        .busy       (busy),
        .brk_frame  (brk_frame),
        .txd        (txd)
    );

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_done);

    p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !busy) |=> !busy);

    p_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && tx_enable && !hold_empty) |=> (busy && !txd));

    p_break_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && tx_enable && send_break && !hold_empty) |=> (!hold_empty && brk_frame));
endmodule

// File: tb/test_ser_tx_dbuf.sv
// Scoreboard bench: driver tasks queue expected frames, a line monitor
// decodes txd by counting baud ticks and compares against the queue.
module test_ser_tx_dbuf;
    typedef struct packed {
        logic       brk;
        logic       nine;
        logic [8:0] word;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_bit9 = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       tx_enable = 1'b0;
    logic       send_break = 1'b0;
    logic       hold_empty, tx_done, txd;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   tp = 1;
    int   tcnt = 0;
    int   b2b = 0;
    bit   mon_busy = 0;
    bit   ended = 0;
    exp_t exp_q[$];

    ser_tx_dbuf i_ser_tx_dbuf (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick     (baud_tick),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_bit9       (wr_bit9),
        .nine_bit_mode (nine_bit_mode),
        .tx_enable     (tx_enable),
        .send_break    (send_break),
        .hold_empty    (hold_empty),
        .tx_done       (tx_done),
        .txd           (txd)
    );

    always #5 clk = ~clk;

    // Baud strobe, one pulse every tp cycles, changed away from the edge.
    always @(negedge clk) begin
        if (tcnt >= tp - 1) begin
            tcnt      <= 0;
            baud_tick <= 1'b1;
        end else begin
            tcnt      <= tcnt + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Count n baud ticks consumed by the design, then land on a negedge.
    task automatic wait_ticks(int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
        @(negedge clk);
    endtask

    function automatic logic [10:0] frame_of(exp_t it);
        if (it.brk)  return 11'h000;
        if (it.nine) return {1'b1, it.word[8], it.word[7:0], 1'b0};
        return {2'b01, it.word[7:0], 1'b0};
    endfunction

    // Monitor: detect start, sample each bit mid-slot, compare with queue.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            while (txd === 1'b0) begin
                exp_t        it;
                logic [10:0] rx;
                int          nb;
                mon_busy = 1;
                rx = '0;
                if (exp_q.size() == 0) begin
                    it = '0;
                    n_cmp++; n_bad++;
                    $display("FAIL R1: actual unexpected frame expected none");
                end else begin
                    it = exp_q.pop_front();
                end
                nb = it.nine ? 11 : 10;
                wait_ticks(8);
                rx[0] = txd;
                for (int i = 1; i < nb; i++) begin
                    wait_ticks(16);
                    rx[i] = txd;
                end
                // R1 R2 R9: full frame content versus expectation
                chk(it.brk ? "R9 break frame" : (it.nine ? "R2 9-bit frame" : "R1 8-bit frame"),
                    32'(rx), 32'(frame_of(it)));
                wait_ticks(8);
                if (txd === 1'b0) b2b++;
                mon_busy = 0;
            end
        end
    end

    // Driver: wait for room, write, queue the expected frame.
    task automatic send(logic [7:0] d, logic b9, bit idle_check);
        exp_t it;
        while (hold_empty !== 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_bit9 = b9;
        it.brk = 1'b0; it.nine = nine_bit_mode; it.word = {b9, d};
        exp_q.push_back(it);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 hold_empty low after write", 32'(hold_empty), 32'h0);
        if (idle_check) begin
            @(negedge clk);
            chk("R5 hold_empty back high after transfer", 32'(hold_empty), 32'h1);
            chk("R7 tx_done low after load", 32'(tx_done), 32'h0);
        end
    endtask

    // Raw write with no expectation (used for ignored writes).
    task automatic poke(logic [7:0] d);
        wr_en = 1'b1; wr_data = d; wr_bit9 = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_break();
        exp_t it;
        it.brk = 1'b1; it.nine = nine_bit_mode; it.word = '0;
        exp_q.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(exp_q.size() == 0 && !mon_busy && tx_done === 1'b1)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run is one failed check, still summarised.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 txd after reset", 32'(txd), 32'h1);
        chk("R11 hold_empty after reset", 32'(hold_empty), 32'h1);
        chk("R11 tx_done after reset", 32'(tx_done), 32'h1);

        // Single 8-bit character from idle
        tx_enable = 1'b1;
        @(negedge clk);
        send(8'hA5, 1'b0, 1);
        wait_idle();
        chk("R7 tx_done high after frame", 32'(tx_done), 32'h1);
        chk("R8 txd idle high", 32'(txd), 32'h1);

        // R6 burst: queued characters follow without gaps
        b0 = b2b;
        send(8'h00, 1'b0, 1);
        send(8'hFF, 1'b0, 0);
        send(8'h3C, 1'b0, 0);
        send(8'h81, 1'b0, 0);
        wait_idle();
        chk("R6 back-to-back boundaries", 32'(b2b - b0), 32'h3);

        // R4 write while full is ignored
        send(8'h11, 1'b0, 1);
        send(8'h22, 1'b0, 0);
        poke(8'h55);
        chk("R4 hold stays full after ignored write", 32'(hold_empty), 32'h0);
        wait_idle();

        // R2 9-bit mode with a slower tick rate
        tp = 3;
        nine_bit_mode = 1'b1;
        @(negedge clk);
        send(8'h12, 1'b1, 1);
        send(8'hF0, 1'b0, 0);
        send(8'h00, 1'b1, 0);
        wait_idle();
        tp = 1;
        nine_bit_mode = 1'b0;
        repeat (4) @(negedge clk);

        // R8 disable mid-frame: current finishes, queued one waits
        send(8'h6E, 1'b0, 1);
        send(8'h97, 1'b0, 0);
        tx_enable = 1'b0;
        while (tx_done !== 1'b1) @(negedge clk);
        repeat (400) @(negedge clk);
        chk("R8 queued char held while disabled", 32'(hold_empty), 32'h0);
        chk("R8 line high while disabled", 32'(txd), 32'h1);
        chk("R8 no frame started while disabled", 32'(exp_q.size()), 32'h1);
        tx_enable = 1'b1;
        wait_idle();

        // R10 break has priority over a waiting character
        tx_enable = 1'b0;
        @(negedge clk);
        push_break();
        send(8'hC3, 1'b0, 0);
        send_break = 1'b1;
        tx_enable = 1'b1;
        @(negedge clk);
        while (tx_done !== 1'b0) @(negedge clk);
        send_break = 1'b0;
        chk("R10 char still waiting during break", 32'(hold_empty), 32'h0);
        chk("R9 line low at break start", 32'(txd), 32'h0);
        wait_idle();

        // R9 break held across two 11-bit frame boundaries
        nine_bit_mode = 1'b1;
        @(negedge clk);
        push_break();
        push_break();
        send_break = 1'b1;
        while (tx_done !== 1'b0) @(negedge clk);
        wait_ticks(11 * 16 + 4);
        chk("R9 line still low in repeated break", 32'(txd), 32'h0);
        send_break = 1'b0;
        wait_idle();
        chk("R9 line high after break", 32'(txd), 32'h1);
        chk("R5 hold_empty high at end", 32'(hold_empty), 32'h1);

        finish_run();
    end
endmodule